// File: doc/BRIEF.md
# Tone-Disable Event Interrupt Queue

This block collects tone-disable events from a large set of echo-canceller channels and hands them to a host processor one at a time. Each channel has two tone-disable detector status inputs, A and B. A scanner visits the channels in turn, one per clock. At each visit it compares both detector levels with the levels it recorded at that channel's previous visit. A change in either direction is an event, so the onset of a tone disable and its release each produce their own event. The number of the channel that raised an unmasked event is written into a FIFO.

An active-low interrupt line tells the host that the FIFO holds entries. The host pops one channel number per read strobe. Each read releases the interrupt line, and the line is driven low again for the next entry still waiting, so the host sees one low pulse per queued event. Every channel has one mask bit for each of its two detectors, and a global mask keeps the interrupt line inactive. A status output reports whether a tone disable is present right now on a channel that the host selects.

Top module: `tdq_event_queue`

## Requirements
- R1: After reset, irq_n_o is 1, ovf_o is 0 and fifo_data_o is all ones. All recorded detector levels start at 0.
- R2: From the first clock after reset, the scanner visits one channel per clock in ascending order, starting at channel 0 and wrapping from NUM_CH-1 back to 0. At a visit, a detector level that differs from the level recorded at that channel's previous visit is an event. This holds for a 0-to-1 change (onset) and for a 1-to-0 change (release).
- R3: If mask_a_i[c] is set, changes of detector A on channel c queue nothing. mask_b_i[c] does the same for detector B. The recorded level is updated at the visit even when the change is masked. A later change of a mask does not alter entries that are already queued.
- R4: A visit with at least one unmasked change pushes one entry, the channel number, into a first-in first-out queue of DEPTH entries. A push into a full queue is accepted when a pop happens in the same cycle.
- R5: A read strobe on a non-empty queue pops the oldest entry and shows it on fifo_data_o from the next cycle on. A read strobe on an empty queue sets fifo_data_o to all ones and leaves the queue and irq_n_o unchanged.
- R6: An event that finds the queue full, with no pop in the same cycle, is dropped and sets ovf_o. ovf_o stays set until reset.
- R7: Unless R8 or R9 applies, irq_n_o in a cycle is 0 exactly when the queue held at least one entry in the previous cycle.
- R8: After a pop, irq_n_o is 1 for the next two cycles: one cycle for the release and at least one cycle of gap. After that it goes low again if entries remain.
- R9: While glb_mask_i is set, irq_n_o is 1 from the next cycle on. Events are still queued.
- R10: stat_td_o is the OR of det_a_i and det_b_i for the channel on stat_sel_i, with no delay. It is 0 when stat_sel_i is not a valid channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| det_a_i | input | NUM_CH | Detector A tone-disable level for each channel |
| det_b_i | input | NUM_CH | Detector B tone-disable level for each channel |
| mask_a_i | input | NUM_CH | Masks detector A events for each channel |
| mask_b_i | input | NUM_CH | Masks detector B events for each channel |
| glb_mask_i | input | 1 | Keeps the interrupt line inactive |
| rd_fifo_i | input | 1 | Read strobe for the queue |
| fifo_data_o | output | CH_W | Channel number from the last read (all ones if the queue was empty) |
| ovf_o | output | 1 | Sticky flag: an event was dropped |
| irq_n_o | output | 1 | Active-low interrupt |
| stat_sel_i | input | CH_W | Channel selected for the status output |
| stat_td_o | output | 1 | Tone disable currently present on the selected channel |

## Verification
Two functions can land in the same cycle: the scanner pushes an event while the host pops the head. This is most telling when the queue is full, because the push must then be accepted rather than counted as an overflow. The random phase produces this case with frequent detector toggles and reads on roughly one cycle in four. A reference queue in the bench, updated at every clock from the requirements, judges the result through the read data, the overflow flag and the interrupt level.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
    typedef struct packed {
        logic irq_n;
        logic hold;
    } irq_st_t;
endpackage

// File: rtl/tdq_scan.sv
module tdq_scan #(
    parameter int NUM_CH = 288,
    parameter int CH_W   = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] det_a,
    input  logic [NUM_CH-1:0] det_b,
    input  logic [NUM_CH-1:0] msk_a,
    input  logic [NUM_CH-1:0] msk_b,
    output logic              ev_valid,
    output logic [CH_W-1:0]   ev_ch
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic [CH_W-1:0]   idx;
        logic [NUM_CH-1:0] pa;
        logic [NUM_CH-1:0] pb;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic cur_a, cur_b, chg_a, chg_b;

    always_comb begin
        st_d  = st_q;
        cur_a = det_a[st_q.idx];
        cur_b = det_b[st_q.idx];
        chg_a = cur_a ^ st_q.pa[st_q.idx];
        chg_b = cur_b ^ st_q.pb[st_q.idx];
        st_d.pa[st_q.idx] = cur_a;
        st_d.pb[st_q.idx] = cur_b;
        st_d.idx = (st_q.idx == LAST) ? '0 : st_q.idx + 1'b1;
        ev_valid = (chg_a & ~msk_a[st_q.idx]) | (chg_b & ~msk_b[st_q.idx]);
        ev_ch    = st_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_scan_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx != LAST) |=> (st_q.idx == $past(st_q.idx) + 1'b1));
    assert_scan_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx == LAST) |=> (st_q.idx == '0));
endmodule

// File: rtl/tdq_fifo.sv
module tdq_fifo #(
    parameter int CH_W  = 9,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [CH_W-1:0] push_ch,
    input  logic            rd_req,
    output logic            pop,
    output logic            not_empty,
    output logic [CH_W-1:0] rd_data,
    output logic            ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LASTP = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][CH_W-1:0] mem;
        logic [PTR_W-1:0]           wp;
        logic [PTR_W-1:0]           rp;
        logic [CNT_W-1:0]           cnt;
        logic                       ovf;
        logic [CH_W-1:0]            rdata;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push;

    always_comb begin
        st_d    = st_q;
        pop     = rd_req && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != FULLC) || pop);
        if (rd_req) st_d.rdata = pop ? st_q.mem[st_q.rp] : '1;
        if (pop) st_d.rp = (st_q.rp == LASTP) ? '0 : st_q.rp + 1'b1;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_ch;
            st_d.wp = (st_q.wp == LASTP) ? '0 : st_q.wp + 1'b1;
        end
        if (push && !do_push) st_d.ovf = 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rdata <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign not_empty = (st_q.cnt != '0);
    assign rd_data   = st_q.rdata;
    assign ovf       = st_q.ovf;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULLC);
    assert_drop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULLC && push && !rd_req) |=> (st_q.ovf && st_q.cnt == FULLC));
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && st_q.cnt == '0) |=> (st_q.rdata == '1 && st_q.cnt == $past(st_q.cnt) + CNT_W'($past(push))));
endmodule

// File: rtl/tdq_irq.sv
module tdq_irq
    import tdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic pop,
    input  logic glb_mask,
    output logic irq_n
);
    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.irq_n = 1'b1;
            st_d.hold  = 1'b1;
        end else if (st_q.hold) begin
            st_d.irq_n = 1'b1;
            st_d.hold  = 1'b0;
        end else begin
            st_d.irq_n = ~(pending & ~glb_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{irq_n: 1'b1, hold: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_n = st_q.irq_n;

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> irq_n);
    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pop, 2) |-> irq_n);
    assert_glb_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        glb_mask |=> irq_n);
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> irq_n);
endmodule

// File: rtl/tdq_event_queue.sv
module tdq_event_queue #(
    parameter int NUM_CH = 288,
    parameter int DEPTH  = 16,
    parameter int CH_W   = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] det_a_i,
    input  logic [NUM_CH-1:0] det_b_i,
    input  logic [NUM_CH-1:0] mask_a_i,
    input  logic [NUM_CH-1:0] mask_b_i,
    input  logic              glb_mask_i,
    input  logic              rd_fifo_i,
    output logic [CH_W-1:0]   fifo_data_o,
    output logic              ovf_o,
    output logic              irq_n_o,
    input  logic [CH_W-1:0]   stat_sel_i,
    output logic              stat_td_o
);
    logic            ev_valid;
    logic [CH_W-1:0] ev_ch;
    logic            pop;
    logic            not_empty;

    tdq_scan #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .det_a(det_a_i), .det_b(det_b_i),
        .msk_a(mask_a_i), .msk_b(mask_b_i),
        .ev_valid(ev_valid), .ev_ch(ev_ch)
    );

    tdq_fifo #(.CH_W(CH_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(ev_valid), .push_ch(ev_ch), .rd_req(rd_fifo_i),
        .pop(pop), .not_empty(not_empty),
        .rd_data(fifo_data_o), .ovf(ovf_o)
    );

    tdq_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .pending(not_empty), .pop(pop), .glb_mask(glb_mask_i),
        .irq_n(irq_n_o)
    );

    always_comb begin
        stat_td_o = 1'b0;
        if (32'(stat_sel_i) < NUM_CH)
            stat_td_o = det_a_i[stat_sel_i] | det_b_i[stat_sel_i];
    end
endmodule

// File: tb/tdq_event_queue_tb_top.sv
module tdq_event_queue_tb_top;
    localparam int NUM_CH = 10;
    localparam int DEPTH  = 4;
    localparam int CH_W   = $clog2(NUM_CH + 1);
    localparam int PERIOD = 10;
    localparam logic [CH_W-1:0] ALL1 = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_CH-1:0] det_a = '0, det_b = '0, msk_a = '0, msk_b = '0;
    logic glb = 1'b0, rd = 1'b0;
    logic [CH_W-1:0] sel = '0;
    logic [CH_W-1:0] fifo_data;
    logic ovf, irq_n, td;

    int n_run = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    tdq_event_queue #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .det_a_i(det_a), .det_b_i(det_b),
        .mask_a_i(msk_a), .mask_b_i(msk_b),
        .glb_mask_i(glb), .rd_fifo_i(rd),
        .fifo_data_o(fifo_data), .ovf_o(ovf), .irq_n_o(irq_n),
        .stat_sel_i(sel), .stat_td_o(td)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, built from the requirements
    bit m_pa[NUM_CH];
    bit m_pb[NUM_CH];
    int m_q[$];
    int m_idx = 0;
    bit m_ovf = 0, m_hold = 0, m_irq = 1, m_rd_seen = 0, m_was_pop = 0;
    int m_rd = int'(ALL1);
    bit m_glb_prev = 0;
    bit chk_en = 0;

    function automatic bit ev_at(input int c);
        bit ca = det_a[c] ^ m_pa[c];
        bit cb = det_b[c] ^ m_pb[c];
        return (ca && !msk_a[c]) || (cb && !msk_b[c]);
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            automatic int old_cnt = m_q.size();
            automatic bit pop = rd && old_cnt > 0;
            automatic bit ev = ev_at(m_idx);
            m_rd_seen = rd;
            m_was_pop = pop;
            if (rd) m_rd = pop ? m_q[0] : int'(ALL1);
            if (pop) begin m_irq = 1; m_hold = 1; end
            else if (m_hold) begin m_irq = 1; m_hold = 0; end
            else m_irq = !(old_cnt > 0 && !glb);
            m_glb_prev = glb;
            m_pa[m_idx] = det_a[m_idx];
            m_pb[m_idx] = det_b[m_idx];
            if (pop) void'(m_q.pop_front());
            if (ev) begin
                if (old_cnt < DEPTH || pop) m_q.push_back(m_idx);
                else m_ovf = 1;
            end
            m_idx = (m_idx == NUM_CH - 1) ? 0 : m_idx + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            chk(irq_n == m_irq, m_glb_prev ? "R9" : (m_hold || m_was_pop) ? "R8" : "R7",
                irq_n, m_irq);
            chk(ovf == m_ovf, "R6", ovf, m_ovf);
            if (m_rd_seen)
                chk(int'(fifo_data) == m_rd, m_was_pop ? "R2 R4" : "R5", fifo_data, m_rd);
        end
    end

    task automatic read_one();
        @(negedge clk); #1 rd = 1'b1;
        @(negedge clk); #1 rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int c = 0; c < NUM_CH; c++) begin m_pa[c] = 0; m_pb[c] = 0; end
        wait_cyc(3);
        chk(irq_n == 1'b1, "R1", irq_n, 1);
        chk(ovf == 1'b0, "R1", ovf, 0);
        chk(fifo_data == ALL1, "R1", fifo_data, ALL1);
        @(negedge clk); rst_n = 1'b1;
        chk_en = 1;

        // read on empty queue
        read_one();
        chk(fifo_data == ALL1 && irq_n, "R5", fifo_data, ALL1);

        // masked detector A changes queue nothing
        msk_a = '1; #1 det_a = '1;
        wait_cyc(NUM_CH + 3);
        chk(irq_n == 1'b1, "R3", irq_n, 1);
        msk_a = '0;
        wait_cyc(NUM_CH + 3);
        chk(irq_n == 1'b1, "R3", irq_n, 1);
        read_one();
        chk(fifo_data == ALL1, "R3", fifo_data, ALL1);

        // status of the selected channel
        sel = CH_W'(2); #1;
        chk(td == 1'b1, "R10", td, 1);
        det_a[2] = 1'b0; #1;
        chk(td == 1'b0, "R10", td, 0);
        sel = CH_W'(NUM_CH); #1;
        chk(td == 1'b0, "R10", td, 0);
        wait_cyc(NUM_CH + 2);
        read_one();
        chk(fifo_data == CH_W'(2), "R2", fifo_data, 2);

        // onset and release on detector B of channel 5
        det_b[5] = 1'b1;
        wait_cyc(NUM_CH + 2);
        chk(irq_n == 1'b0, "R7", irq_n, 0);
        read_one();
        chk(fifo_data == CH_W'(5), "R2", fifo_data, 5);
        det_b[5] = 1'b0;
        wait_cyc(NUM_CH + 2);
        read_one();
        chk(fifo_data == CH_W'(5), "R2", fifo_data, 5);

        // random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk); #1;
            if ($urandom % 3 == 0) det_a[$urandom % NUM_CH] ^= 1'b1;
            if ($urandom % 3 == 0) det_b[$urandom % NUM_CH] ^= 1'b1;
            rd = ($urandom % 4 == 0);
            if (cyc % 256 == 0) begin
                msk_a = NUM_CH'($urandom) & NUM_CH'($urandom);
                msk_b = NUM_CH'($urandom) & NUM_CH'($urandom);
            end
            if (cyc % 600 == 300) glb = 1'b1;
            if (cyc % 600 == 450) glb = 1'b0;
            sel = CH_W'($urandom % (NUM_CH + 2));
            #1;
            chk(td == ((int'(sel) < NUM_CH) ? (det_a[sel] | det_b[sel]) : 1'b0), "R10", td, 0);
        end
        rd = 1'b0; glb = 1'b0;

        // overflow: all channels change, no reads
        det_a = ~det_a; msk_a = '0; msk_b = '0;
        wait_cyc(NUM_CH + 3);
        chk(ovf == 1'b1, "R6", ovf, 1);
        for (int i = 0; i < DEPTH + 1; i++) read_one();
        wait_cyc(3);
        chk(irq_n == 1'b1 && ovf == 1'b1, "R6", irq_n, 1);

        chk_en = 0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule